// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block watches the pins of a two-port, sixteen-pin I/O expander and raises an interrupt request when an input pin has moved away from the value the port last captured. Each port holds a snapshot of its pins. This snapshot is the value a host sees when it reads that port's input register. A pin counts toward the interrupt only while its direction bit marks it as an input.

A port's pending flag drops in one of two ways. The first is that every differing pin returns to its snapshot value. The second is that the host reads that port: the read-acknowledge strobe for the port takes a new snapshot of its pins. Each port keeps its own snapshot and its own pending flag, so a read of one port does not affect the other port. The interrupt output is an enable for an open-drain pad driver. When it is high, the pad pulls the shared interrupt line low.

The pins arrive already synchronised. The bus decoder supplies the acknowledge strobes, and only for reads addressed to this device. Any other bus traffic never reaches the block. The pad itself lies outside this block.

Top module: `pin_change_irq`

## Requirements
- R1: During reset, every pending flag, the interrupt enable and every snapshot bit are 0. On the first clock edge after reset release, each port copies its pins into its snapshot and leaves its pending flag at 0.
- R2: After that first edge, an input pin (direction bit 1) that differs from its snapshot bit at a clock edge sets that port's pending flag at that edge.
- R3: A pin whose direction bit is 0 (output) never sets a pending flag, whatever its level.
- R4: When, at a clock edge, no input pin of a port differs from its snapshot and no acknowledge is present, that port's pending flag is 0 after the edge.
- R5: An acknowledge strobe for port p that is high at a clock edge copies port p's pins into its snapshot and clears port p's pending flag at that edge.
- R6: Without its own acknowledge, a port's snapshot does not change. An acknowledge for the other port leaves this port's snapshot and pending flag unaffected.
- R7: Changing a pin's direction bit from 0 to 1 while its level differs from its snapshot sets the pending flag at the next clock edge.
- R8: The interrupt enable is 1 exactly when at least one port's pending flag is 1.
- R9: A pin change that meets a read acknowledge at the same edge is absorbed into the new snapshot. It raises nothing while the pin stays put, and a later change raises the flag again.
- Port 0 is pin bits 7:0 and port 1 is bits 15:8. Acknowledge bit p belongs to port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 16 | Synchronised pin levels, port 0 in bits 7:0 |
| dir_in_i | input | 16 | Direction bits, 1 = input |
| rd_ack_i | input | 2 | Per-port read-acknowledge strobe |
| snap_o | output | 16 | Latched input-register value per port |
| port_pend_o | output | 2 | Per-port pending-change flags |
| irq_drive_low_o | output | 1 | Open-drain enable, 1 pulls the interrupt line low |

## Verification
The bench checks reads that land on one port while both ports are pending. A design that cleared globally would drop the other port's flag or overwrite its snapshot. It also checks an output pin toggled under a stale snapshot, and the same pin then turned into an input. A design that ignored direction would raise the flag early, and one that masked the flag permanently would never raise it. Finally, it drives a pin change on the very edge of an acknowledge. A design that captured the pins one cycle late, or cleared the flag one cycle early, would then show a spurious flag or lose the re-raise.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

    localparam int unsigned PCIRQ_PORT_W = 8;
    localparam int unsigned PCIRQ_NPORTS = 2;

    typedef enum logic [0:0] {
        PH_PRIME = 1'b0,
        PH_WATCH = 1'b1
    } pcirq_phase_e;

endpackage

// File: rtl/pcirq_port.sv
module pcirq_port
    import pcirq_pkg::*;
#(
    parameter int unsigned W = PCIRQ_PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic [W-1:0] dir_in_i,
    input  logic         rd_ack_i,
    output logic [W-1:0] snap_o,
    output logic         pend_o
);

    typedef struct packed {
        pcirq_phase_e phase;
        logic [W-1:0] snap;
        logic         pend;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [W-1:0] diff_w;

    // Input pins that currently disagree with the captured snapshot.
    assign diff_w = (pins_i ^ st_q.snap) & dir_in_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_PRIME: begin
                st_d.snap  = pins_i;
                st_d.pend  = 1'b0;
                st_d.phase = PH_WATCH;
            end
            PH_WATCH: begin
                if (rd_ack_i) begin
                    st_d.snap = pins_i;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.pend = |diff_w;
                end
            end
            default: st_d.phase = PH_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_PRIME;
            st_q.snap  <= '0;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o = st_q.snap;
    assign pend_o = st_q.pend;

    p_prime_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PRIME) |=> !pend_o);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WATCH && rd_ack_i) |=> !pend_o);

    p_ack_relatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WATCH && rd_ack_i) |=> (snap_o == $past(pins_i)));

    p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WATCH && !rd_ack_i) |=> $stable(snap_o));

    p_outputs_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ack_i && dir_in_i == '0) |=> !pend_o);

endmodule

// File: rtl/pcirq_merge.sv
module pcirq_merge #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] pend_i,
    output logic         drive_low_o
);

    logic [N:0] acc_w;

    assign acc_w[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_or
        assign acc_w[g+1] = acc_w[g] | pend_i[g];
    end

    assign drive_low_o = acc_w[N];

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pcirq_pkg::*;
#(
    parameter int unsigned PORT_W = PCIRQ_PORT_W,
    parameter int unsigned NPORTS = PCIRQ_NPORTS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS*PORT_W-1:0] pins_i,
    input  logic [NPORTS*PORT_W-1:0] dir_in_i,
    input  logic [NPORTS-1:0]        rd_ack_i,
    output logic [NPORTS*PORT_W-1:0] snap_o,
    output logic [NPORTS-1:0]        port_pend_o,
    output logic                     irq_drive_low_o
);

    localparam int unsigned TOTAL_W = NPORTS * PORT_W;

    logic [TOTAL_W-1:0] snap_w;
    logic [NPORTS-1:0]  pend_w;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pcirq_port #(.W(PORT_W)) i_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins_i   (pins_i[p*PORT_W +: PORT_W]),
            .dir_in_i (dir_in_i[p*PORT_W +: PORT_W]),
            .rd_ack_i (rd_ack_i[p]),
            .snap_o   (snap_w[p*PORT_W +: PORT_W]),
            .pend_o   (pend_w[p])
        );
    end

    pcirq_merge #(.N(NPORTS)) i_merge (
        .pend_i      (pend_w),
        .drive_low_o (irq_drive_low_o)
    );

    assign snap_o      = snap_w;
    assign port_pend_o = pend_w;

    p_irq_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_pend_o == '0) |-> !irq_drive_low_o);

    p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(port_pend_o) > 0) |-> irq_drive_low_o);

endmodule

// File: tb/test_pin_change_irq.sv
module test_pin_change_irq;

    localparam int  PW      = 8;
    localparam int  NP      = 2;
    localparam int  TW      = PW * NP;
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] pins = '0;
    logic [TW-1:0] dir = '1;
    logic [NP-1:0] ack = '0;
    logic [TW-1:0] snap;
    logic [NP-1:0] pend;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [TW-1:0] snap;
        logic [NP-1:0] pend;
        logic          irq;
        string         tag;
    } exp_t;

    exp_t sbq[$];

    logic [TW-1:0] mdl_snap = '0;
    bit            mdl_primed = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    pin_change_irq i_pin_change_irq (
        .clk             (clk),
        .rst_n           (rst_n),
        .pins_i          (pins),
        .dir_in_i        (dir),
        .rd_ack_i        (ack),
        .snap_o          (snap),
        .port_pend_o     (pend),
        .irq_drive_low_o (irq)
    );

    // Driver: called at a falling edge, predicts state after the next rising edge.
    task automatic step(input logic [TW-1:0] p, input logic [TW-1:0] d,
                        input logic [NP-1:0] a, input string tag);
        exp_t e;
        pins = p;
        dir  = d;
        ack  = a;
        e.pend = '0;
        if (!mdl_primed) begin
            mdl_snap   = p;
            mdl_primed = 1'b1;
        end else begin
            for (int k = 0; k < NP; k++) begin
                if (a[k]) begin
                    mdl_snap[k*PW +: PW] = p[k*PW +: PW];
                end else begin
                    e.pend[k] = |((p[k*PW +: PW] ^ mdl_snap[k*PW +: PW]) & d[k*PW +: PW]);
                end
            end
        end
        e.snap = mdl_snap;
        e.irq  = |e.pend;
        e.tag  = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compares just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_tests++;
                if (snap !== e.snap || pend !== e.pend || irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: snap=%h pend=%b irq=%b expected snap=%h pend=%b irq=%b",
                             e.tag, snap, pend, irq, e.snap, e.pend, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        pins = 16'hA55A;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_tests++;
        if (pend !== 2'b00 || irq !== 1'b0 || snap !== '0) begin
            n_fail++;
            $display("FAIL R1: pend=%b irq=%b snap=%h expected pend=00 irq=0 snap=0000",
                     pend, irq, snap);
        end
        rst_n = 1'b1;
        step(16'hA55A, 16'hFFFF, 2'b00, "R1");
        step(16'hA55B, 16'hFFFF, 2'b00, "R2");
        step(16'hA55A, 16'hFFFF, 2'b00, "R4");
        step(16'hA5FF, 16'hFF00, 2'b00, "R3");
        step(16'hA5FF, 16'hFF00, 2'b00, "R3");
        step(16'hA5FF, 16'hFFFF, 2'b00, "R7");
        step(16'h5AFF, 16'hFFFF, 2'b00, "R8");
        step(16'h5AFF, 16'hFFFF, 2'b01, "R5");
        step(16'h5AFF, 16'hFFFF, 2'b00, "R6");
        step(16'h5BFF, 16'hFFFF, 2'b10, "R9");
        step(16'h5BFF, 16'hFFFF, 2'b00, "R9");
        step(16'h5AFF, 16'hFFFF, 2'b00, "R9");
        step(16'h5AFF, 16'h00FF, 2'b00, "R3");
        step(16'h5BFF, 16'hFFFF, 2'b00, "R4");
        lf = 32'h1D2C_3B4A;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[15:0] & (lf[20] ? 16'hFFFF : 16'h0F0F),
                 {lf[27:20], lf[31:24]},
                 {lf[29] & lf[30], lf[28] & lf[26]}, "R8");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule